// File: doc/BRIEF.md
# Starvation Window Monitor with Injection Duty Throttle

This unit sits on one mesh node, between the flit queue of the node and its deflection router. In every cycle it decides whether the flit at the head of the queue may enter the network. A flit can only enter when the router reports a free output link. On top of that rule, a programmable duty gate holds back a set share of the attempts that would otherwise have gone through. The throttle rate comes from a controller outside this block.

The unit also measures congestion as seen from the node. A cycle counts as starved when the node wants to inject but does not. This happens when no link is free or when the throttle holds the flit back. The unit keeps the exact number of starved cycles among the most recent 128 cycles. That number, divided by the window length, gives the starvation rate that the outside controller reads.

Top module: `starve_throttle_top`

## Requirements
- R1: After synchronous reset, starve_count is 0, the duty counter is at 0 and the registered rate is 0.
- R2: A cycle with inject_req low never grants and enters the window as not starved.
- R3: A cycle with inject_req high and link_free low never grants and enters the window as starved.
- R4: With a registered rate of 0, every attempt that finds a free link is granted.
- R5: With a constant registered rate R (0 to 127), exactly R of any 128 consecutive eligible attempts are refused and 128-R are granted. An eligible attempt is one with inject_req and link_free both high. An attempt is granted when the 7-bit duty counter is greater than or equal to R. The counter wraps modulo 128.
- R6: The duty counter advances by one on each eligible attempt, whether that attempt is granted or refused. It holds on every other cycle.
- R7: An eligible attempt that the throttle refuses enters the window as starved. A granted attempt enters as not starved.
- R8: rate_in is registered. A value presented in one cycle governs the grant decisions from the next cycle on.
- R9: After each clock edge, starve_count equals the number of starved cycles among the last 128 cycles completed since reset.
- R10: starve_count never exceeds 128 and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inject_req | input | 1 | Queue holds a flit that wants to enter the network |
| link_free | input | 1 | Router has a free output link this cycle |
| rate_in | input | 7 | Throttle rate in units of 1/128 |
| inject_grant | output | 1 | Flit enters the network this cycle |
| starve_count | output | 8 | Starved cycles in the last 128 cycles |

## Verification
The checker verifies several rules on every cycle. A grant never appears without both a request and a free link. A rate of 0 registered in the previous cycle never refuses an eligible attempt. The window count stays within 0..128 and moves by at most one per cycle. An idle cycle never raises the count, and a link-blocked cycle never lowers it. Some behaviour spans up to 128 cycles, so only the bench scenarios can show it. These scenarios cover the exact number of refusals over a whole duty period, the counter holding still through link-busy cycles, the window filling to exactly 128 and draining to 0, and the one-cycle delay on a rate change.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int unsigned STQ_WIN   = 128;
  localparam int unsigned STQ_CTR_W = 7;

  // classification of one cycle at the injection port
  typedef enum logic [1:0] {
    SLOT_IDLE      = 2'd0,
    SLOT_SENT      = 2'd1,
    SLOT_LINK_BUSY = 2'd2,
    SLOT_THROTTLED = 2'd3
  } slot_e;

  function automatic logic slot_starved(input slot_e s);
    return (s == SLOT_LINK_BUSY) || (s == SLOT_THROTTLED);
  endfunction
endpackage

// File: rtl/stq_rate_gate.sv
// Duty gate: a counter that steps on each eligible attempt, compared against
// the registered rate. Refuses rate_q out of every 2**CTR_W eligible attempts.
module stq_rate_gate #(
  parameter int CTR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTR_W-1:0] rate_in,
  input  logic             eligible,
  output logic             allow
);
  localparam logic [CTR_W-1:0] STEP = CTR_W'(1);

  logic [CTR_W-1:0] ctr_q;
  logic [CTR_W-1:0] rate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q  <= '0;
      rate_q <= '0;
    end else begin
      rate_q <= rate_in;
      if (eligible) ctr_q <= ctr_q + STEP;
    end
  end

  assign allow = (ctr_q >= rate_q);
endmodule

// File: rtl/stq_window.sv
// Exact sliding window: shift register of per-cycle bits plus running count.
module stq_window #(
  parameter int WIN   = 128,
  parameter int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [CNT_W-1:0] count
);
  logic [WIN-1:0]   hist_q;
  logic             bit_out;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (WIN > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[WIN-2:0], bit_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= bit_in;
      end
    end
  endgenerate

  assign bit_out = hist_q[WIN-1];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (bit_in && !bit_out) cnt_q <= cnt_q + CNT_W'(1);
    else if (!bit_in && bit_out) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign count = cnt_q;
endmodule

// File: rtl/starve_throttle_top.sv
module starve_throttle_top #(
  parameter int WIN   = stq_pkg::STQ_WIN,
  parameter int CTR_W = stq_pkg::STQ_CTR_W,
  parameter int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inject_req,
  input  logic             link_free,
  input  logic [CTR_W-1:0] rate_in,
  output logic             inject_grant,
  output logic [CNT_W-1:0] starve_count
);
  import stq_pkg::*;

  logic  eligible;
  logic  allow;
  slot_e slot;

  assign eligible = inject_req & link_free;

  stq_rate_gate #(.CTR_W(CTR_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .rate_in  (rate_in),
    .eligible (eligible),
    .allow    (allow)
  );

  always_comb begin
    if (!inject_req)    slot = SLOT_IDLE;
    else if (!link_free) slot = SLOT_LINK_BUSY;
    else if (allow)      slot = SLOT_SENT;
    else                 slot = SLOT_THROTTLED;
  end

  assign inject_grant = (slot == SLOT_SENT);

  stq_window #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .bit_in (slot_starved(slot)),
    .count  (starve_count)
  );
endmodule

// File: rtl/starve_throttle_chk.sv
module starve_throttle_chk #(
  parameter int WIN   = 128,
  parameter int CTR_W = 7,
  parameter int CNT_W = $clog2(WIN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             inject_req,
  input logic             link_free,
  input logic [CTR_W-1:0] rate_in,
  input logic             inject_grant,
  input logic [CNT_W-1:0] starve_count
);
  localparam logic [CNT_W-1:0] WIN_V = CNT_W'(WIN);

  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (rst)
    !inject_req |-> !inject_grant);

  assert_busy_no_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (inject_req && !link_free) |-> !inject_grant);

  assert_idle_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !inject_req |=> (starve_count <= $past(starve_count)));

  assert_busy_no_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (inject_req && !link_free) |=> (starve_count >= $past(starve_count)));

  assert_zero_rate_grants_R4: assert property (@(posedge clk) disable iff (rst)
    (inject_req && link_free && ($past(rate_in) == '0)) |-> inject_grant);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    starve_count <= WIN_V);

  assert_unit_step_R10: assert property (@(posedge clk) disable iff (rst)
    (starve_count == $past(starve_count)) ||
    (starve_count == ($past(starve_count) + CNT_W'(1))) ||
    ((starve_count + CNT_W'(1)) == $past(starve_count)));
endmodule

bind starve_throttle_top starve_throttle_chk #(.WIN(WIN), .CTR_W(CTR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .inject_req   (inject_req),
  .link_free    (link_free),
  .rate_in      (rate_in),
  .inject_grant (inject_grant),
  .starve_count (starve_count)
);

// File: tb/sim_starve_throttle_top.sv
module sim_starve_throttle_top;
  localparam int WIN   = 128;
  localparam int CTR_W = 7;
  localparam int CNT_W = 8;
  localparam int PER   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inject_req = 1'b0;
  logic             link_free = 1'b0;
  logic [CTR_W-1:0] rate_in = '0;
  logic             inject_grant;
  logic [CNT_W-1:0] starve_count;

  always #(PER/2) clk = ~clk;

  starve_throttle_top u0 (
    .clk(clk), .rst(rst), .inject_req(inject_req), .link_free(link_free),
    .rate_in(rate_in), .inject_grant(inject_grant), .starve_count(starve_count)
  );

  typedef struct {
    logic  g;
    int    c;
    string tag;
  } item_t;

  item_t q[$];
  int errs = 0;
  int checks = 0;
  int tally = 0;

  // reference state built from the requirements
  int m_ctr = 0, m_rate = 0, m_cnt = 0, m_idx = 0;
  bit hist [WIN];

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic l, input int rt, input string tag);
    item_t it;
    bit    elig, g, starved;
    @(negedge clk);
    inject_req = r; link_free = l; rate_in = CTR_W'(rt);
    elig    = r && l;
    g       = elig && (m_ctr >= m_rate);
    starved = r && !g;
    if (elig) m_ctr = (m_ctr + 1) % 128;
    m_rate  = rt;
    m_cnt   = m_cnt + int'(starved) - int'(hist[m_idx]);
    hist[m_idx] = starved;
    m_idx   = (m_idx + 1) % WIN;
    it.g = g; it.c = m_cnt; it.tag = tag;
    q.push_back(it);
    #3;
    if (inject_grant) tally++;
  endtask

  // monitor: pops expectations, grant before the edge, count after it
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(inject_grant == it.g, {it.tag, " grant"}, int'(inject_grant), int'(it.g));
        @(posedge clk);
        #1;
        check(int'(starve_count) == it.c, {it.tag, " count"}, int'(starve_count), it.c);
      end
    end
  end

  initial begin
    #(PER * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    foreach (hist[i]) hist[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #3;
    check(starve_count == 0, "R1 reset count", int'(starve_count), 0);
    check(inject_grant == 1'b0, "R1 reset grant", int'(inject_grant), 0);

    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 0, "R2 idle");
    // first attempt after reset: registered rate still 0
    step(1'b1, 1'b1, 9, "R8 reset rate");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 9, "R5 rate9");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 0, "R4 rate0");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 0, "R3 link busy");

    // one full duty period at rate 40
    step(1'b1, 1'b1, 40, "R8 settle");
    tally = 0;
    for (int i = 0; i < 128; i++) step(1'b1, 1'b1, 40, "R5 rate40");
    check(tally == 88, "R5 grants per period", tally, 88);

    // busy cycles interleaved: counter holds, period still exact
    tally = 0;
    for (int i = 0; i < 128; i++) begin
      step(1'b1, 1'b1, 40, "R6 eligible");
      step(1'b1, 1'b0, 40, "R6 busy");
    end
    check(tally == 88, "R6 grants with busy gaps", tally, 88);

    // fill window with throttled and link-busy starvation
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 127, "R7 throttled");
    for (int i = 0; i < 140; i++) step(1'b1, 1'b0, 127, "R9 fill");
    @(posedge clk); #1;
    check(starve_count == 128, "R10 saturated", int'(starve_count), 128);

    for (int i = 0; i < 130; i++) step(1'b0, 1'b0, 0, "R9 drain");
    @(posedge clk); #1;
    check(starve_count == 0, "R9 drained", int'(starve_count), 0);

    // rate changing every cycle
    for (int i = 0; i < 200; i++)
      step((i % 3) != 0, (i % 5) != 0, (i * 37) % 128, "R8 rate sweep");

    wait (q.size() == 0);
    @(posedge clk); #2;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule